// File: doc/BRIEF.md
# Program-Flash Self-Programming Controller

This block lets software running on the core alter its own program flash. Through a small register bus the core loads a 16-bit target address split across two byte registers, loads a data byte, and then writes a command code into a control register. The controller checks the command against the loaded address, then runs a read, a bit-clearing byte write, a 64-byte page erase or a whole-array erase against a behavioural flash array through a start/done handshake. While an operation runs, the address and data registers are frozen and further commands are refused with an error flag.

The top byte of the array is the option byte. Software reads it through the alias address 0xFFFF. Bit 0 of that byte selects where the core fetches from after reset. The bit is stored inverted, so an erased byte selects the boot ROM. The selection is captured only on a reset edge. An exit command raises a one-cycle reset request so that a newly programmed choice can take effect.

Top module: `flash_prog_ctl`

## Requirements
- R1: During and after reset, both address registers read 0x00, busy and err are 0 and rst_req is 0. The flash contents are kept through reset.
- R2: Register offsets are 0 address high (bits 15..8), 1 address low (bits 7..0), 2 write data, 3 read data and 4 control. A bus read returns the selected register on bus_rdata one cycle later. A control read gives busy in bit 7 and err in bit 6, with the other bits 0. Writing control with bits [2:0] = 1 reads the byte at the loaded address into the read-data register.
- R3: Code 2 writes the byte: the stored value becomes the old value ANDed with the write-data register. Busy stays high for 3 cycles.
- R4: Code 3 sets the 64 bytes of the page to 0xFF when the address is in range and its low 6 bits are zero, with busy high for 66 cycles. A misaligned address is rejected: err is set and nothing is erased.
- R5: Code 4 sets every byte, the option byte included, to 0xFF, with busy high for 2 + array-size cycles. It is accepted only when the address is 0x0000. Any other address is rejected with err.
- R6: A read at 0xFFFF returns the option byte, which is stored at the top array location (0x7FF by default). Any other address at or above the array size is rejected with err for read, write and page erase.
- R7: While busy, writes to the address and write-data registers have no effect. A command written while busy is not started and sets err.
- R8: An accepted command clears err. Codes 6 and 7 are rejected with err. Busy rises on the edge that accepts a command and falls 2 + n edges later, where n is 0 for a read, 1 for a write and the byte count for an erase. The read-data register is updated on the edge where busy falls.
- R9: Code 5, written while idle, drives rst_req high for exactly one cycle and does not set busy.
- R10: fetch_from_flash is loaded on each reset edge with the inverse of option-byte bit 0, so 1 means start at flash 0x0000 and 0 means boot ROM. It does not change between resets, even when the option byte is reprogrammed or erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data of the selected register |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Last command was rejected |
| rst_req | output | 1 | One-cycle reset request from the exit command |
| fetch_from_flash | output | 1 | Reset fetch source: 1 flash 0x0000, 0 boot ROM |

## Verification
Writing the same byte twice with different data tells a bit-clearing write apart from a plain overwrite, because only the AND of the two values passes. Page erases are issued at aligned and misaligned addresses. A byte is read back both inside and outside the erased page, which tells a correct page bound from an erase that is off by one page. Mass erase at zero and at a non-zero address shows the address guard working. Reads at 0xFFFF, at the physical option location and just past the array separate the alias from plain range rejection. Commands and address writes issued while busy check that the operands stay frozen. Programming the option byte, then issuing exit and then reset, shows that the fetch source changes only on the reset edge.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_READ = 3'd1,
    CMD_PROG = 3'd2,
    CMD_PAGE = 3'd3,
    CMD_BULK = 3'd4,
    CMD_EXIT = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    OP_RD = 2'd0,
    OP_WR = 2'd1,
    OP_ER = 2'd2
  } op_e;

  localparam logic [2:0] REG_AHI  = 3'd0;
  localparam logic [2:0] REG_ALO  = 3'd1;
  localparam logic [2:0] REG_WDAT = 3'd2;
  localparam logic [2:0] REG_RDAT = 3'd3;
  localparam logic [2:0] REG_CTRL = 3'd4;

  localparam logic [15:0] OPT_ALIAS = 16'hFFFF;
endpackage

// File: rtl/fpc_cmd_regs.sv
module fpc_cmd_regs
  import flash_prog_pkg::*;
#(
  parameter int FLASH_AW = 11,
  parameter int PAGE_AW  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          bus_addr,
  input  logic                bus_we,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic                busy,
  output logic                err,
  output logic                rst_req,
  output logic                fl_start,
  output op_e                 fl_op,
  output logic [FLASH_AW-1:0] fl_first,
  output logic [FLASH_AW-1:0] fl_last,
  output logic [7:0]          fl_wdata,
  input  logic                fl_done,
  input  logic [7:0]          fl_rdata,
  output logic [7:0]          addr_hi
);
  localparam logic [FLASH_AW-1:0] TOP_ADDR  = '1;
  localparam logic [FLASH_AW-1:0] PAGE_MASK = FLASH_AW'((1 << PAGE_AW) - 1);

  logic [7:0]          addr_lo, wdat_q, rdat_q;
  logic [15:0]         addr_full;
  logic                in_range, aligned, cmd_wr, cmd_ok, is_exit, cur_read;
  op_e                 dec_op;
  logic [FLASH_AW-1:0] dec_first, dec_last;
  cmd_e                code;

  assign addr_full = {addr_hi, addr_lo};
  assign in_range  = (addr_full >> FLASH_AW) == 16'd0;
  assign aligned   = (addr_full[FLASH_AW-1:0] & PAGE_MASK) == '0;
  assign code      = cmd_e'(bus_wdata[2:0]);
  assign cmd_wr    = bus_we && (bus_addr == REG_CTRL) && (code != CMD_NONE);
  assign fl_wdata  = wdat_q;

  // command check against the held address
  always_comb begin
    cmd_ok    = 1'b0;
    is_exit   = 1'b0;
    dec_op    = OP_RD;
    dec_first = addr_full[FLASH_AW-1:0];
    dec_last  = addr_full[FLASH_AW-1:0];
    case (code)
      CMD_READ: begin
        if (addr_full == OPT_ALIAS) begin
          cmd_ok    = 1'b1;
          dec_first = TOP_ADDR;
          dec_last  = TOP_ADDR;
        end else begin
          cmd_ok = in_range;
        end
      end
      CMD_PROG: begin
        dec_op = OP_WR;
        cmd_ok = in_range;
      end
      CMD_PAGE: begin
        dec_op   = OP_ER;
        cmd_ok   = in_range && aligned;
        dec_last = addr_full[FLASH_AW-1:0] | PAGE_MASK;
      end
      CMD_BULK: begin
        dec_op    = OP_ER;
        cmd_ok    = (addr_full == 16'd0);
        dec_first = '0;
        dec_last  = TOP_ADDR;
      end
      CMD_EXIT: begin
        cmd_ok  = 1'b1;
        is_exit = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hi   <= 8'h00;
      addr_lo   <= 8'h00;
      busy      <= 1'b0;
      err       <= 1'b0;
      rst_req   <= 1'b0;
      fl_start  <= 1'b0;
      fl_op     <= OP_RD;
      fl_first  <= '0;
      fl_last   <= '0;
      cur_read  <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      fl_start <= 1'b0;
      rst_req  <= 1'b0;
      case (bus_addr)
        REG_AHI:  bus_rdata <= addr_hi;
        REG_ALO:  bus_rdata <= addr_lo;
        REG_WDAT: bus_rdata <= wdat_q;
        REG_RDAT: bus_rdata <= rdat_q;
        REG_CTRL: bus_rdata <= {busy, err, 6'b0};
        default:  bus_rdata <= 8'h00;
      endcase
      if (fl_done) busy <= 1'b0;
      if (bus_we && !busy) begin
        if (bus_addr == REG_AHI) addr_hi <= bus_wdata;
        if (bus_addr == REG_ALO) addr_lo <= bus_wdata;
      end
      if (cmd_wr) begin
        if (busy || !cmd_ok) begin
          err <= 1'b1;
        end else begin
          err <= 1'b0;
          if (is_exit) begin
            rst_req <= 1'b1;
          end else begin
            busy     <= 1'b1;
            fl_start <= 1'b1;
            fl_op    <= dec_op;
            fl_first <= dec_first;
            fl_last  <= dec_last;
            cur_read <= (dec_op == OP_RD);
          end
        end
      end
    end
  end

  // data bytes carry no reset value
  always_ff @(posedge clk) begin
    if (bus_we && !busy && bus_addr == REG_WDAT) wdat_q <= bus_wdata;
    if (fl_done && cur_read) rdat_q <= fl_rdata;
  end
endmodule

// File: rtl/fpc_flash_array.sv
module fpc_flash_array
  import flash_prog_pkg::*;
#(
  parameter int FLASH_AW = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  op_e                 op,
  input  logic [FLASH_AW-1:0] first,
  input  logic [FLASH_AW-1:0] last,
  input  logic [7:0]          wdata,
  output logic                done,
  output logic [7:0]          rdata,
  output logic                wr_stb,
  output logic [FLASH_AW-1:0] wr_addr,
  output logic [7:0]          wr_byte
);
  localparam int DEPTH = 1 << FLASH_AW;

  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_ERASE} st_e;

  st_e                 st;
  logic [FLASH_AW-1:0] cnt;
  logic [7:0]          mem [DEPTH];
  logic [7:0]          q;
  logic                mem_we;
  logic [FLASH_AW-1:0] mem_a;
  logic [7:0]          mem_d;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_comb begin
    mem_we = 1'b0;
    mem_a  = first;
    mem_d  = q & wdata;
    case (st)
      ST_PROG:  mem_we = 1'b1;
      ST_ERASE: begin
        mem_we = 1'b1;
        mem_a  = cnt;
        mem_d  = 8'hFF;
      end
      default: ;
    endcase
  end

  // single-port array, read-first
  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_a] <= mem_d;
    q <= mem[mem_a];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          case (op)
            OP_WR:   st <= ST_PROG;
            OP_ER: begin
              cnt <= first;
              st  <= ST_ERASE;
            end
            default: done <= 1'b1;
          endcase
        end
        ST_PROG: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        ST_ERASE: begin
          cnt <= cnt + 1'b1;
          if (cnt == last) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rdata   = q;
  assign wr_stb  = mem_we;
  assign wr_addr = mem_a;
  assign wr_byte = mem_d;
endmodule

// File: rtl/fpc_boot_sel.sv
module fpc_boot_sel #(
  parameter int FLASH_AW = 11,
  parameter int BOOT_BIT = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  logic [FLASH_AW-1:0] wr_addr,
  input  logic [7:0]          wr_byte,
  output logic                from_flash
);
  localparam logic [FLASH_AW-1:0] OPT_ADDR = '1;

  logic [7:0] opt_q = 8'hFF;

  // shadow of the option byte, follows every array write to it
  always_ff @(posedge clk) begin
    if (wr_stb && wr_addr == OPT_ADDR) opt_q <= wr_byte;
  end

  // stored bit is active-low so that erased means boot ROM
  always_ff @(posedge clk) begin
    if (rst) from_flash <= ~opt_q[BOOT_BIT];
  end
endmodule

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl
  import flash_prog_pkg::*;
#(
  parameter int FLASH_AW = 11,
  parameter int PAGE_AW  = 6,
  parameter int BOOT_BIT = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       busy,
  output logic       err,
  output logic       rst_req,
  output logic       fetch_from_flash
);
  logic                fl_start, fl_done, wr_stb;
  op_e                 fl_op;
  logic [FLASH_AW-1:0] fl_first, fl_last, wr_addr;
  logic [7:0]          fl_wdata, fl_rdata, wr_byte, ahi_w;

  fpc_cmd_regs #(.FLASH_AW(FLASH_AW), .PAGE_AW(PAGE_AW)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .err(err),
    .rst_req(rst_req), .fl_start(fl_start), .fl_op(fl_op),
    .fl_first(fl_first), .fl_last(fl_last), .fl_wdata(fl_wdata),
    .fl_done(fl_done), .fl_rdata(fl_rdata), .addr_hi(ahi_w)
  );

  fpc_flash_array #(.FLASH_AW(FLASH_AW)) u_array (
    .clk(clk), .rst(rst), .start(fl_start), .op(fl_op), .first(fl_first),
    .last(fl_last), .wdata(fl_wdata), .done(fl_done), .rdata(fl_rdata),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_byte(wr_byte)
  );

  fpc_boot_sel #(.FLASH_AW(FLASH_AW), .BOOT_BIT(BOOT_BIT)) u_boot (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_byte(wr_byte), .from_flash(fetch_from_flash)
  );
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker
  import flash_prog_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] bus_addr,
  input logic       bus_we,
  input logic [2:0] cmd_bits,
  input logic       busy,
  input logic       err,
  input logic       rst_req,
  input logic       fetch_from_flash,
  input logic [7:0] addr_hi
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!busy && !err && !rst_req && addr_hi == 8'h00));  // R1

  AST_HOLD_AHI: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr == REG_AHI) |=> addr_hi == $past(addr_hi));  // R7

  AST_BUSY_CMD_ERR: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr == REG_CTRL && cmd_bits != 3'd0) |=> err);  // R7

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);  // R9

  AST_EXIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !busy);  // R9

  AST_BOOT_STABLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(fetch_from_flash));  // R10
endmodule

bind flash_prog_ctl fpc_checker u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .cmd_bits(bus_wdata[2:0]), .busy(busy), .err(err), .rst_req(rst_req),
  .fetch_from_flash(fetch_from_flash), .addr_hi(ahi_w)
);

// File: tb/sim_flash_prog_ctl.sv
module sim_flash_prog_ctl;
  localparam int DEPTH = 2048;
  localparam int PAGE  = 64;
  localparam int OPT   = DEPTH - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       busy, err, rst_req, fetch_from_flash;

  always #2.5 clk = ~clk;

  flash_prog_ctl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .err(err),
    .rst_req(rst_req), .fetch_from_flash(fetch_from_flash)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done_flag = 1'b0;

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // reference model
  logic [7:0] fm [DEPTH];
  int         m_cnt = 0;
  bit         m_err = 0, m_req = 0, m_boot = 0, m_live = 0;
  logic [7:0] m_ahi = 0, m_alo = 0, m_wd = 0, m_rd = 0, m_rdata = 0;
  bit         m_wd_ok = 0, m_rd_ok = 0, m_rdata_ok = 0;

  initial begin
    for (int i = 0; i < DEPTH; i++) fm[i] = 8'hFF;
  end

  always @(posedge clk) begin : model
    int  a, n, code;
    bit  pre_busy, ok;
    if (rst) begin
      m_ahi = 0; m_alo = 0; m_cnt = 0; m_err = 0; m_req = 0;
      m_rdata = 0; m_rdata_ok = 1; m_live = 1;
      m_boot = ~fm[OPT][0];
    end else begin
      pre_busy = (m_cnt > 0);
      m_rdata_ok = 1;
      case (bus_addr)
        3'd0: m_rdata = m_ahi;
        3'd1: m_rdata = m_alo;
        3'd2: begin m_rdata = m_wd; m_rdata_ok = m_wd_ok; end
        3'd3: begin m_rdata = m_rd; m_rdata_ok = m_rd_ok && !pre_busy; end
        3'd4: m_rdata = {pre_busy, m_err, 6'b0};
        default: m_rdata = 0;
      endcase
      m_req = 0;
      if (m_cnt > 0) m_cnt--;
      if (bus_we) begin
        if (!pre_busy && bus_addr == 3'd0) m_ahi = bus_wdata;
        if (!pre_busy && bus_addr == 3'd1) m_alo = bus_wdata;
        if (!pre_busy && bus_addr == 3'd2) begin m_wd = bus_wdata; m_wd_ok = 1; end
        if (bus_addr == 3'd4 && bus_wdata[2:0] != 0) begin
          code = int'(bus_wdata[2:0]);
          a = {m_ahi, m_alo};
          if (pre_busy) m_err = 1;
          else begin
            ok = 0; n = 0;
            case (code)
              1: if (a == 16'hFFFF) begin ok = 1; m_rd = fm[OPT]; end
                 else if (a < DEPTH) begin ok = 1; m_rd = fm[a]; end
              2: if (a < DEPTH) begin ok = 1; n = 1; fm[a] = fm[a] & m_wd; end
              3: if (a < DEPTH && a % PAGE == 0) begin
                   ok = 1; n = PAGE;
                   for (int i = 0; i < PAGE; i++) fm[a+i] = 8'hFF;
                 end
              4: if (a == 0) begin
                   ok = 1; n = DEPTH;
                   for (int i = 0; i < DEPTH; i++) fm[i] = 8'hFF;
                 end
              5: begin ok = 1; n = -1; m_req = 1; end
              default: ok = 0;
            endcase
            if (ok) begin
              m_err = 0;
              if (code == 1) m_rd_ok = 1;
              if (n >= 0) m_cnt = n + 2;
            end else m_err = 1;
          end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (m_live && !done_flag) begin
      check("R8 busy", int'(busy), int'(m_cnt > 0));
      check("R7 err", int'(err), int'(m_err));
      check("R9 rst_req", int'(rst_req), int'(m_req));
      check("R10 fetch_from_flash", int'(fetch_from_flash), int'(m_boot));
      if (m_rdata_ok) check({tag, " bus_rdata"}, int'(bus_rdata), int'(m_rdata));
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
    bus_addr = a; bus_we = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr_reg(3'd0, a[15:8]);
    wr_reg(3'd1, a[7:0]);
  endtask

  task automatic cmd(input logic [2:0] c);
    wr_reg(3'd4, {5'b0, c});
    wait_idle();
  endtask

  task automatic fread(input logic [15:0] a, output logic [7:0] v);
    set_addr(a);
    cmd(3'd1);
    rd_reg(3'd3, v);
  endtask

  task automatic fwrite(input logic [15:0] a, input logic [7:0] d);
    set_addr(a);
    wr_reg(3'd2, d);
    cmd(3'd2);
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin : stim
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    tag = "R1";
    check("R1 busy in reset", int'(busy), 0);
    check("R1 err in reset", int'(err), 0);
    check("R10 boot ROM when erased", int'(fetch_from_flash), 0);
    rst = 1'b0;
    rd_reg(3'd0, v); check("R1 addr hi reset", int'(v), 8'h00);
    rd_reg(3'd1, v); check("R1 addr lo reset", int'(v), 8'h00);

    // R2 read of erased byte, control layout
    tag = "R2";
    fread(16'h0005, v); check("R2 erased read", int'(v), 8'hFF);
    rd_reg(3'd4, v); check("R2 control idle", int'(v), 8'h00);

    // R3 write clears bits only
    tag = "R3";
    set_addr(16'h0005);
    wr_reg(3'd2, 8'hA5);
    wr_reg(3'd4, 8'd2);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R3 write busy cycles", n, 3);
    fwrite(16'h0005, 8'h3C);
    fread(16'h0005, v); check("R3 AND of two writes", int'(v), 8'h24);
    fwrite(16'h0123, 8'h5A);
    fread(16'h0123, v); check("R3 second location", int'(v), 8'h5A);
    fwrite(16'h0140, 8'h11);

    // R4 page erase
    tag = "R4";
    set_addr(16'h0100);
    wr_reg(3'd4, 8'd3);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R4 page erase busy cycles", n, 66);
    fread(16'h0123, v); check("R4 byte in page erased", int'(v), 8'hFF);
    fread(16'h0140, v); check("R4 next page untouched", int'(v), 8'h11);
    fread(16'h0005, v); check("R4 other page untouched", int'(v), 8'h24);
    set_addr(16'h0141);
    wr_reg(3'd4, 8'd3);
    check("R4 misaligned rejected", int'(err), 1);
    check("R4 misaligned not busy", int'(busy), 0);
    fread(16'h0140, v); check("R4 misaligned no erase", int'(v), 8'h11);

    // R6 option alias and range
    tag = "R6";
    fread(16'hFFFF, v); check("R6 alias erased option", int'(v), 8'hFF);
    fwrite(16'h07FF, 8'hFE);
    fread(16'hFFFF, v); check("R6 alias after program", int'(v), 8'hFE);
    check("R10 no change before reset", int'(fetch_from_flash), 0);
    set_addr(16'h0800);
    wr_reg(3'd4, 8'd1);
    check("R6 out of range read rejected", int'(err), 1);
    wr_reg(3'd4, 8'd2);
    check("R6 out of range write rejected", int'(err), 1);

    // R8 unknown code and err clearing
    tag = "R8";
    fread(16'h0005, v);
    check("R8 accepted clears err", int'(err), 0);
    wr_reg(3'd4, 8'd6);
    check("R8 code 6 rejected", int'(err), 1);
    wr_reg(3'd4, 8'd7);
    check("R8 code 7 rejected", int'(err), 1);

    // R7 busy lock
    tag = "R7";
    set_addr(16'h0140);
    wr_reg(3'd2, 8'h77);
    wr_reg(3'd4, 8'd3);
    wr_reg(3'd0, 8'h12);
    wr_reg(3'd2, 8'h00);
    wr_reg(3'd4, 8'd1);
    check("R7 command while busy sets err", int'(err), 1);
    check("R7 still busy", int'(busy), 1);
    wait_idle();
    rd_reg(3'd0, v); check("R7 addr hi frozen", int'(v), 8'h01);
    rd_reg(3'd2, v); check("R7 write data frozen", int'(v), 8'h77);

    // R5 mass erase
    tag = "R5";
    fwrite(16'h0300, 8'h42);
    set_addr(16'h0040);
    wr_reg(3'd4, 8'd4);
    check("R5 nonzero address rejected", int'(err), 1);
    fread(16'h0300, v); check("R5 rejected keeps data", int'(v), 8'h42);

    // R9 exit and R10 boot select
    tag = "R9";
    wr_reg(3'd4, 8'd5);
    check("R9 request high", int'(rst_req), 1);
    check("R9 no busy on exit", int'(busy), 0);
    @(negedge clk);
    check("R9 request one cycle", int'(rst_req), 0);
    tag = "R10";
    check("R10 fetch before reset", int'(fetch_from_flash), 0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R10 flash fetch after reset", int'(fetch_from_flash), 1);
    rd_reg(3'd0, v); check("R1 addr hi after reset", int'(v), 8'h00);
    fread(16'h0300, v); check("R1 flash kept through reset", int'(v), 8'h42);

    tag = "R5";
    set_addr(16'h0000);
    wr_reg(3'd4, 8'd4);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R5 mass erase busy cycles", n, DEPTH + 2);
    fread(16'h0300, v); check("R5 data erased", int'(v), 8'hFF);
    fread(16'hFFFF, v); check("R5 option erased", int'(v), 8'hFF);
    check("R10 erase no effect before reset", int'(fetch_from_flash), 1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R10 boot ROM after reset", int'(fetch_from_flash), 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule